// File: doc/BRIEF.md
# Memory Issue Policy Scheduler

This block chooses, on every clock cycle, at most one memory operation in a circular load/store queue to issue next. Each queue slot describes one operation with a set of flags: whether the slot is in use, whether the operation is a store, whether its address is ready, whether its store data is ready, and whether it has already issued. A store is treated as two halves, address and data, and each half's readiness is tracked on its own flag. Program age is measured from a head pointer, with wrap-around, so the slot at the head is the oldest.

A two-bit policy input picks how far loads may run ahead of older stores. The choices run from strict program order, to free reordering of loads among themselves with stores as barriers, to loads waiting only for older store addresses, to loads issuing as soon as their own address is ready. Stores never pass any older unissued operation. The grant is registered and appears one cycle after the queue state it was computed from. Alongside it, a flag reports when the granted load was allowed to pass an older store whose address was still unknown, so that later logic can treat that load as speculative.

The queue depth must be a power of two.

Top module: `mem_issue_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, `grant` is all zero and `grantValid` and `specLoad` are 0.
- R2: `grant` is one-hot or zero and changes one clock edge after the inputs it is computed from. Among the eligible slots it selects the oldest, where the slot at `headPtr` is oldest and age increases with slot index modulo DEPTH. `grantValid` is 1 exactly when `grant` is non-zero.
- R3: A slot can be granted only if `entValid` is 1 and `entIssued` is 0 for it. A load (`entStore`=0) also needs `entAddrRdy`=1. A store (`entStore`=1) also needs both `entAddrRdy`=1 and `entDataRdy`=1.
- R4: Under every policy, a store is granted only when no older slot is valid and unissued.
- R5: With `policy`=0, a load is granted only when no older slot is valid and unissued. This is strict program order.
- R6: With `policy`=1, a load is blocked by any older valid unissued store, and it is not blocked by older loads.
- R7: With `policy`=2, a load is blocked only by an older valid unissued store whose `entAddrRdy` is 0. An older store whose data is not ready does not block it.
- R8: With `policy`=3, a load needs only its own readiness from R3, whatever the state of older stores.
- R9: `specLoad` is 1, in the same cycle as the grant, exactly when the granted operation is a load and some older valid unissued store had `entAddrRdy`=0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy | input | 2 | Ordering policy select, 0 to 3 |
| headPtr | input | log2(DEPTH) | Slot index of the oldest queue entry |
| entValid | input | DEPTH | Slot holds an operation |
| entStore | input | DEPTH | Operation is a store (1) or a load (0) |
| entAddrRdy | input | DEPTH | Address half is ready |
| entDataRdy | input | DEPTH | Store data half is ready |
| entIssued | input | DEPTH | Operation has already issued |
| grant | output | DEPTH | One-hot grant, registered |
| grantValid | output | 1 | A grant is present this cycle |
| specLoad | output | 1 | Granted load passed an older store whose address was unknown |

## Verification
The hardest cases to reach are those where the result depends on the relative age of a blocking store and a ready load when the queue wraps past the last slot. The policy decides whether a store with its address ready but its data missing, or an older store with no address, blocks the load. To reach every such arrangement, the bench sweeps all type, address-ready and data-ready combinations of a four-slot queue. Each combination runs under every head position and every policy, with two kinds of valid and issued masks. A small arithmetic model in the bench predicts the grant and the speculation flag for each one. Directed cases first pin down reset, wrap-around order, store ordering and the speculation flag with hand-computed values.

// File: rtl/memsched_pkg.sv
package memsched_pkg;

  typedef enum logic [1:0] {
    POL_IN_ORDER   = 2'd0,
    POL_LOAD_FREE  = 2'd1,
    POL_WAIT_ADDR  = 2'd2,
    POL_EAGER      = 2'd3
  } policy_e;

  typedef struct packed {
    logic headOnly;
    logic stallOnStore;
    logic stallOnAddr;
    logic markSpec;
  } sched_strobe_t;

endpackage

// File: rtl/memsched_ctrl.sv
module memsched_ctrl
  import memsched_pkg::*;
(
  input  logic [1:0]    policy,
  output sched_strobe_t strobe
);

  policy_e pol;

  always_comb begin
    pol = policy_e'(policy);
    strobe = '0;
    unique case (pol)
      POL_IN_ORDER:  strobe.headOnly     = 1'b1;
      POL_LOAD_FREE: strobe.stallOnStore = 1'b1;
      POL_WAIT_ADDR: strobe.stallOnAddr  = 1'b1;
      POL_EAGER:     strobe.markSpec     = 1'b1;
      default:       strobe = '0;
    endcase
  end

endmodule

// File: rtl/memsched_pick.sv
module memsched_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k] && !found) begin
        gnt[k] = 1'b1;
        found  = 1'b1;
      end
    end
    any = found;
  end

endmodule

// File: rtl/memsched_dp.sv
module memsched_dp
  import memsched_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  sched_strobe_t    strobe,
  input  logic [IDX_W-1:0] headPtr,
  input  logic [DEPTH-1:0] entValid,
  input  logic [DEPTH-1:0] entStore,
  input  logic [DEPTH-1:0] entAddrRdy,
  input  logic [DEPTH-1:0] entDataRdy,
  input  logic [DEPTH-1:0] entIssued,
  output logic [DEPTH-1:0] grant,
  output logic             grantValid,
  output logic             specLoad
);

  // queue state rotated so that position 0 is the oldest slot
  logic [DEPTH-1:0] pendAge, storeAge, addrAge, dataAge;
  logic [DEPTH-1:0] olderPend, olderStore, olderNoAddr;
  logic [DEPTH-1:0] readyAge, eligAge, pickAge;
  logic [DEPTH-1:0] grantNext;
  logic             pickAny;
  logic             specNext;

  always_comb begin
    logic [IDX_W-1:0] idx;
    for (int k = 0; k < DEPTH; k++) begin
      idx         = headPtr + IDX_W'(k);
      pendAge[k]  = entValid[idx] & ~entIssued[idx];
      storeAge[k] = entStore[idx];
      addrAge[k]  = entAddrRdy[idx];
      dataAge[k]  = entDataRdy[idx];
    end
  end

  // running summaries of everything older than each position
  always_comb begin
    logic runPend, runStore, runNoAddr;
    runPend   = 1'b0;
    runStore  = 1'b0;
    runNoAddr = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      olderPend[k]   = runPend;
      olderStore[k]  = runStore;
      olderNoAddr[k] = runNoAddr;
      runPend   = runPend   | pendAge[k];
      runStore  = runStore  | (pendAge[k] & storeAge[k]);
      runNoAddr = runNoAddr | (pendAge[k] & storeAge[k] & ~addrAge[k]);
    end
  end

  always_comb begin
    logic loadOk;
    for (int k = 0; k < DEPTH; k++) begin
      readyAge[k] = addrAge[k] & (dataAge[k] | ~storeAge[k]);
      if (strobe.headOnly)          loadOk = ~olderPend[k];
      else if (strobe.stallOnStore) loadOk = ~olderStore[k];
      else if (strobe.stallOnAddr)  loadOk = ~olderNoAddr[k];
      else                          loadOk = 1'b1;
      eligAge[k] = pendAge[k] & readyAge[k] &
                   (storeAge[k] ? ~olderPend[k] : loadOk);
    end
  end

  memsched_pick #(.N(DEPTH)) uPick (
    .req (eligAge),
    .gnt (pickAge),
    .any (pickAny)
  );

  // rotate the age-ordered pick back to slot positions
  always_comb begin
    logic [IDX_W-1:0] idx;
    grantNext = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = headPtr + IDX_W'(k);
      grantNext[idx] = pickAge[k];
    end
  end

  assign specNext = strobe.markSpec & |(pickAge & ~storeAge & olderNoAddr);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= '0;
      grantValid <= 1'b0;
      specLoad   <= 1'b0;
    end else begin
      grant      <= grantNext;
      grantValid <= pickAny;
      specLoad   <= specNext;
    end
  end

endmodule

// File: rtl/mem_issue_sched.sv
module mem_issue_sched
  import memsched_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       policy,
  input  logic [IDX_W-1:0] headPtr,
  input  logic [DEPTH-1:0] entValid,
  input  logic [DEPTH-1:0] entStore,
  input  logic [DEPTH-1:0] entAddrRdy,
  input  logic [DEPTH-1:0] entDataRdy,
  input  logic [DEPTH-1:0] entIssued,
  output logic [DEPTH-1:0] grant,
  output logic             grantValid,
  output logic             specLoad
);

  sched_strobe_t strobe;

  memsched_ctrl uCtrl (
    .policy (policy),
    .strobe (strobe)
  );

  memsched_dp #(.DEPTH(DEPTH)) uDp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .headPtr    (headPtr),
    .entValid   (entValid),
    .entStore   (entStore),
    .entAddrRdy (entAddrRdy),
    .entDataRdy (entDataRdy),
    .entIssued  (entIssued),
    .grant      (grant),
    .grantValid (grantValid),
    .specLoad   (specLoad)
  );

endmodule

// File: rtl/memsched_chk.sv
module memsched_chk #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       policy,
  input logic [DEPTH-1:0] entValid,
  input logic [DEPTH-1:0] entStore,
  input logic [DEPTH-1:0] entAddrRdy,
  input logic [DEPTH-1:0] entDataRdy,
  input logic [DEPTH-1:0] entIssued,
  input logic [DEPTH-1:0] grant,
  input logic             grantValid,
  input logic             specLoad
);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_valid_flag_r2: assert property (@(posedge clk) disable iff (rst)
    grantValid == (grant != '0));

  p_pending_r3: assert property (@(posedge clk) disable iff (rst)
    grantValid |-> ((grant & $past(entValid) & ~$past(entIssued)) != '0));

  p_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (grant & ~($past(entAddrRdy) & ($past(entDataRdy) | ~$past(entStore)))) == '0);

  p_spec_load_r9: assert property (@(posedge clk) disable iff (rst)
    specLoad |-> (grantValid && ((grant & $past(entStore)) == '0)));

  p_spec_eager_r8: assert property (@(posedge clk) disable iff (rst)
    specLoad |-> ($past(policy) == 2'd3));

endmodule

bind mem_issue_sched memsched_chk #(.DEPTH(DEPTH)) uChk (
  .clk        (clk),
  .rst        (rst),
  .policy     (policy),
  .entValid   (entValid),
  .entStore   (entStore),
  .entAddrRdy (entAddrRdy),
  .entDataRdy (entDataRdy),
  .entIssued  (entIssued),
  .grant      (grant),
  .grantValid (grantValid),
  .specLoad   (specLoad)
);

// File: tb/tb_mem_issue_sched.sv
`timescale 1ns/1ps
module tb_mem_issue_sched;

  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    policy = '0;
  logic [IW-1:0] headPtr = '0;
  logic [N-1:0]  entValid = '0, entStore = '0, entAddrRdy = '0;
  logic [N-1:0]  entDataRdy = '0, entIssued = '0;
  logic [N-1:0]  grant;
  logic          grantValid, specLoad;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mem_issue_sched #(.DEPTH(N)) dut (
    .clk(clk), .rst(rst), .policy(policy), .headPtr(headPtr),
    .entValid(entValid), .entStore(entStore), .entAddrRdy(entAddrRdy),
    .entDataRdy(entDataRdy), .entIssued(entIssued),
    .grant(grant), .grantValid(grantValid), .specLoad(specLoad)
  );

  task automatic check(string tag, logic [N-1:0] actG, logic [N-1:0] expG,
                       logic actV, logic actS, logic expS);
    total++;
    if (actG !== expG || actV !== (expG != '0)) begin
      bad++;
      if (bad < 20)
        $display("FAIL %s grant act=%b/%b exp=%b/%b", tag, actG, actV, expG, expG != '0);
    end
    total++;
    if (actS !== expS) begin
      bad++;
      if (bad < 20) $display("FAIL R9 (%s) spec act=%b exp=%b", tag, actS, expS);
    end
  endtask

  // Bench model of the selection rules
  task automatic model(input logic [1:0] pol, input int head,
                       input logic [N-1:0] v, s, a, d, iss,
                       output logic [N-1:0] g, output logic sp);
    bit oPend, oSt, oNoA, done;
    oPend = 0; oSt = 0; oNoA = 0; done = 0;
    g = '0; sp = 0;
    for (int k = 0; k < N; k++) begin
      int i;
      bit pend, rdy, ok;
      i = (head + k) % N;
      pend = v[i] && !iss[i];
      rdy = a[i] && (d[i] || !s[i]);
      if (s[i]) ok = !oPend;
      else case (pol)
        2'd0: ok = !oPend;
        2'd1: ok = !oSt;
        2'd2: ok = !oNoA;
        default: ok = 1;
      endcase
      if (!done && pend && rdy && ok) begin
        g[i] = 1'b1;
        sp = !s[i] && oNoA;
        done = 1;
      end
      if (pend) begin
        oPend = 1;
        if (s[i]) begin
          oSt = 1;
          if (!a[i]) oNoA = 1;
        end
      end
    end
  endtask

  task automatic run(string tag, logic [1:0] pol, int head,
                     logic [N-1:0] v, s, a, d, iss,
                     logic [N-1:0] expG, logic expS);
    @(negedge clk);
    policy = pol; headPtr = IW'(head);
    entValid = v; entStore = s; entAddrRdy = a; entDataRdy = d; entIssued = iss;
    @(posedge clk);
    #1;
    check(tag, grant, expG, grantValid, specLoad, expS);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tags[4];
    tags[0] = "R5"; tags[1] = "R6"; tags[2] = "R7"; tags[3] = "R8";
    // R1: everything ready during reset, still no grant
    policy = 2'd3; entValid = '1; entAddrRdy = '1; entDataRdy = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", grant, '0, grantValid, specLoad, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 after release", grant, '0, grantValid, specLoad, 1'b0);

    // R2: oldest from head, with wrap
    run("R2 head3", 2'd3, 3, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1000, 0);
    run("R2 head0", 2'd3, 0, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0001, 0);
    run("R2 wrap",  2'd3, 3, 4'b0011, 4'b0000, 4'b0011, 4'b0000, 4'b0000, 4'b0001, 0);
    // R3: issued/invalid/unready never granted
    run("R3 issued", 2'd3, 0, 4'b1111, 4'b0000, 4'b1111, 4'b1111, 4'b1111, 4'b0000, 0);
    run("R3 st nodata", 2'd3, 0, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 0);
    // R4: store waits for older unready load even in policy 3
    run("R4 store order", 2'd3, 0, 4'b0011, 4'b0010, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 0);
    // R5: in-order blocks a ready younger load
    run("R5 in order", 2'd0, 1, 4'b0110, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 0);
    // R6: loads pass loads, not stores
    run("R6 load pass", 2'd1, 1, 4'b0110, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0100, 0);
    run("R6 store block", 2'd1, 0, 4'b0011, 4'b0001, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 0);
    // R7: store with address but no data does not block
    run("R7 addr known", 2'd2, 0, 4'b0011, 4'b0001, 4'b0011, 4'b0000, 4'b0000, 4'b0010, 0);
    run("R7 addr unknown", 2'd2, 0, 4'b0011, 4'b0001, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 0);
    // R8 + R9: eager load passes unknown-address store and is flagged
    run("R8 eager spec", 2'd3, 0, 4'b0011, 4'b0001, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 1);
    run("R9 no spec", 2'd3, 0, 4'b0011, 4'b0001, 4'b0011, 4'b0000, 4'b0000, 4'b0010, 0);

    // Near-exhaustive sweep: all type/addr/data combinations, heads, policies
    for (int c = 0; c < 4096; c++) begin
      for (int pass = 0; pass < 2; pass++) begin
        for (int h = 0; h < N; h++) begin
          for (int p = 0; p < 4; p++) begin
            logic [N-1:0] s, a, d, v, iss, eg;
            logic es;
            s = c[3:0]; a = c[7:4]; d = c[11:8];
            if (pass == 0) begin
              v = 4'b1111; iss = 4'b0000;
            end else begin
              v = c[5:2] ^ c[11:8] ^ 4'b1010;
              iss = c[9:6] & c[3:0];
            end
            model(2'(p), h, v, s, a, d, iss, eg, es);
            run(tags[p], 2'(p), h, v, s, a, d, iss, eg, es);
          end
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule